// File: doc/BRIEF.md
# Line Transfer and Precharge Sequencer

This block sits between the line-acquisition logic and the analog output stage of a column driver for an active-matrix panel. It watches two transfer-control levels, `xfer_a` and `xfer_b`, and the shift clock. When `xfer_a` drops while `xfer_b` is still high, the next rising clock edge copies the whole acquired line, `CHANNELS` words of `DATA_W` bits, into a storage register. From then on the input line may be refilled for the following row. The storage register is not disturbed by that refill.

After the copy, the block turns the levels of the two controls into four phase signals for the output stage: precharge, convert, latch-to-output and drive. Each phase is decoded from the present control levels, so it follows the controls with no clock delay. A clocked state register records only how far through the ordering the line has come. If the controls step out of order, a sticky error flag is raised. The sequencer then falls back to its idle state, and no line is driven until a fresh copy has taken place.

Top module: `line_xfer_seq`

## Requirements
- R1: After reset `seq_err` is 0 and `line_held` is all zero. `drive_en` stays 0 while both controls are high, because no line has been copied yet.
- R2: `precharge` is 1 in any state exactly when `xfer_a` or `xfer_b` is 0. It follows the control levels in the same cycle.
- R3: From idle or drive, the first rising edge that sees `xfer_a`=0 and `xfer_b`=1 loads `line_in` into `line_held`. Channel k occupies bits [k*DATA_W +: DATA_W]. `line_held` keeps its value on every other edge.
- R4: While the controls stay at `xfer_a`=0, `xfer_b`=1 after the copy, changing `line_in` leaves `line_held` unchanged.
- R5: `dac_convert` is 1 while both controls are 0 and the sequencer has passed the copy step (it is in the copied or convert state).
- R6: `dac_latch` is 1 while `xfer_a`=1 and `xfer_b`=0, once the convert step has been reached.
- R7: `drive_en` is 1 while both controls are 1 after the latch step. It stays 1 during the next line's acquisition until `xfer_a` falls.
- R8: At most one of `dac_convert`, `dac_latch` and `drive_en` is 1 at a time, and `drive_en` is never 1 together with `precharge`.
- R9: A control-level pair that is not the current or the next legal step sets `seq_err` on that edge. The flag stays set until reset, and the sequencer returns to idle with `drive_en` 0.
- R10: After an error, a complete legal sequence still copies the line and reaches drive, while `seq_err` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfer_a | input | 1 | Transfer control one; falling while `xfer_b` is high requests the copy |
| xfer_b | input | 1 | Transfer control two |
| line_in | input | CHANNELS*DATA_W | Acquired line, channel k at bits [k*DATA_W +: DATA_W] |
| line_held | output | CHANNELS*DATA_W | Storage register feeding the converters |
| precharge | output | 1 | Panel precharge enable, outputs disconnected from the converters |
| dac_convert | output | 1 | Converter convert phase |
| dac_latch | output | 1 | Converter output latch phase |
| drive_en | output | 1 | Output drive enable |
| seq_err | output | 1 | Sticky out-of-order sequence flag |

## Verification
A wrong state register shows at the ports within the same cycle that the controls take their next level pair. The expected phase output fails to rise, or an unexpected one rises. A missed or repeated copy shows on `line_held` one edge after the copy request, when the line data has already changed. A wrong error decision shows on `seq_err` at the following edge, and again later, because after a false error `drive_en` never comes up for the line.

// File: rtl/lxs_pkg.sv
package lxs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COPIED  = 3'd1,
    ST_CONVERT = 3'd2,
    ST_LATCH   = 3'd3,
    ST_DRIVE   = 3'd4
  } seq_state_e;

  // control level pair, {xfer_a, xfer_b}
  localparam logic [1:0] LVL_ACQ  = 2'b11;
  localparam logic [1:0] LVL_COPY = 2'b01;
  localparam logic [1:0] LVL_CONV = 2'b00;
  localparam logic [1:0] LVL_LAT  = 2'b10;

endpackage

// File: rtl/lxs_rst_sync.sv
module lxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lxs_fsm.sv
module lxs_fsm
  import lxs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_a,
  input  logic xfer_b,
  output logic copy_en,
  output logic precharge,
  output logic dac_convert,
  output logic dac_latch,
  output logic drive_en,
  output logic seq_err
);

  seq_state_e st_q, st_d;
  logic       err_q, err_set;
  logic [1:0] lvl;

  assign lvl = {xfer_a, xfer_b};

  // next-state decode
  always_comb begin
    st_d    = st_q;
    err_set = 1'b0;
    copy_en = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DRIVE: begin
        if (lvl == LVL_COPY) begin
          copy_en = 1'b1;
          st_d    = ST_COPIED;
        end else if (lvl != LVL_ACQ) begin
          err_set = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_COPIED: begin
        if (lvl == LVL_CONV) begin
          st_d = ST_CONVERT;
        end else if (lvl != LVL_COPY) begin
          err_set = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_CONVERT: begin
        if (lvl == LVL_LAT) begin
          st_d = ST_LATCH;
        end else if (lvl != LVL_CONV) begin
          err_set = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_LATCH: begin
        if (lvl == LVL_ACQ) begin
          st_d = ST_DRIVE;
        end else if (lvl != LVL_LAT) begin
          err_set = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: begin
        err_set = 1'b1;
        st_d    = ST_IDLE;
      end
    endcase
  end

  // state and sticky flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  // phase outputs follow control levels without a clock
  assign precharge   = (lvl != LVL_ACQ);
  assign dac_convert = ((st_q == ST_COPIED)  || (st_q == ST_CONVERT)) && (lvl == LVL_CONV);
  assign dac_latch   = ((st_q == ST_CONVERT) || (st_q == ST_LATCH))   && (lvl == LVL_LAT);
  assign drive_en    = ((st_q == ST_LATCH)   || (st_q == ST_DRIVE))   && (lvl == LVL_ACQ);
  assign seq_err     = err_q;

  // R5: convert state is only entered from the copied step
  a_r5_convert_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONVERT) |-> ($past(st_q) == ST_COPIED || $past(st_q) == ST_CONVERT));

  // R7: drive state is only entered from the latch step
  a_r7_drive_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRIVE) |-> ($past(st_q) == ST_LATCH || $past(st_q) == ST_DRIVE));

  // R9: the error flag never clears without reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9: a fresh error leaves the sequencer idle
  a_r9_err_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (st_q == ST_IDLE));

endmodule

// File: rtl/lxs_store.sv
module lxs_store #(
  parameter int CHANNELS = 240,
  parameter int DATA_W   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_en,
  input  logic [CHANNELS*DATA_W-1:0]   line_in,
  output logic [CHANNELS*DATA_W-1:0]   line_q
);

  localparam int LINE_W = CHANNELS * DATA_W;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (load_en) word_q <= line_in[g*DATA_W +: DATA_W];
    end

    assign line_q[g*DATA_W +: DATA_W] = word_q;
  end

  // R3: the held line changes only on a load edge
  a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(line_q[LINE_W-1:0]));

endmodule

// File: rtl/line_xfer_seq.sv
module line_xfer_seq #(
  parameter int CHANNELS = 240,
  parameter int DATA_W   = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        xfer_a,
  input  logic                        xfer_b,
  input  logic [CHANNELS*DATA_W-1:0]  line_in,
  output logic [CHANNELS*DATA_W-1:0]  line_held,
  output logic                        precharge,
  output logic                        dac_convert,
  output logic                        dac_latch,
  output logic                        drive_en,
  output logic                        seq_err
);

  logic rst_s_n;
  logic copy_en;

  lxs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  lxs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .xfer_a      (xfer_a),
    .xfer_b      (xfer_b),
    .copy_en     (copy_en),
    .precharge   (precharge),
    .dac_convert (dac_convert),
    .dac_latch   (dac_latch),
    .drive_en    (drive_en),
    .seq_err     (seq_err)
  );

  lxs_store #(.CHANNELS(CHANNELS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load_en (copy_en),
    .line_in (line_in),
    .line_q  (line_held)
  );

  // R8: phases are mutually exclusive
  a_r8_one_phase: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({dac_convert, dac_latch, drive_en}));

  // R8: drive never overlaps precharge
  a_r8_drive_not_precharge: assert property (@(posedge clk) disable iff (!rst_s_n)
    drive_en |-> !precharge);

endmodule

// File: tb/line_xfer_seq_bench.sv
module line_xfer_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CH = 240;
  localparam int DW = 6;
  localparam int LW = CH * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          xa = 1'b1;
  logic          xb = 1'b1;
  logic [LW-1:0] lin = '0;
  logic [LW-1:0] held;
  logic          pre, conv, lat, drv, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  line_xfer_seq #(.CHANNELS(CH), .DATA_W(DW)) u_line_xfer_seq (
    .clk(clk), .rst_n(rst_n), .xfer_a(xa), .xfer_b(xb), .line_in(lin),
    .line_held(held), .precharge(pre), .dac_convert(conv), .dac_latch(lat),
    .drive_en(drv), .seq_err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [LW-1:0] mk(int seed);
    logic [LW-1:0] v;
    for (int c = 0; c < CH; c++) v[c*DW +: DW] = DW'((c*7 + seed*13 + 3) % 64);
    return v;
  endfunction

  task automatic chk(string req, string what, bit ok, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 copied, 2 convert, 3 latch, 4 drive
  int            m_st;
  logic [LW-1:0] m_hold;
  bit            m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_hold = '0; m_err = 0;
    end else begin
      case (m_st)
        0, 4: if (!xa && xb) begin m_hold = lin; m_st = 1; end
              else if (!(xa && xb)) begin m_err = 1; m_st = 0; end
        1: if (!xa && !xb) m_st = 2;
           else if (!(!xa && xb)) begin m_err = 1; m_st = 0; end
        2: if (xa && !xb) m_st = 3;
           else if (!(!xa && !xb)) begin m_err = 1; m_st = 0; end
        3: if (xa && xb) m_st = 4;
           else if (!(xa && !xb)) begin m_err = 1; m_st = 0; end
        default: m_st = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      chk("R2", "precharge", pre === !(xa && xb), 64'(pre), 64'(!(xa && xb)));
      chk("R5", "dac_convert", conv === ((m_st == 1 || m_st == 2) && !xa && !xb),
          64'(conv), 64'((m_st == 1 || m_st == 2) && !xa && !xb));
      chk("R6", "dac_latch", lat === ((m_st == 2 || m_st == 3) && xa && !xb),
          64'(lat), 64'((m_st == 2 || m_st == 3) && xa && !xb));
      chk("R7", "drive_en", drv === ((m_st == 3 || m_st == 4) && xa && xb),
          64'(drv), 64'((m_st == 3 || m_st == 4) && xa && xb));
      chk("R9", "seq_err", err === m_err, 64'(err), 64'(m_err));
      chk("R3", "line_held", held === m_hold, held[63:0], m_hold[63:0]);
      chk("R8", "phase overlap", $countones({conv, lat, drv}) <= 1 && !(drv && pre),
          64'({conv, lat, drv}), 64'(0));
    end
  end

  task automatic step(bit a, bit b, int seed);
    @(negedge clk);
    xa = a; xb = b; lin = mk(seed);
  endtask

  task automatic settle();
    #(CLK_PERIOD/4 + 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; xa = 1; xb = 1;
    repeat (3) @(negedge clk);
    settle();
    chk("R1", "held at reset", held === '0, held[63:0], 64'(0));
    chk("R1", "err at reset", err === 1'b0, 64'(err), 64'(0));
    chk("R1", "drive at reset", drv === 1'b0, 64'(drv), 64'(0));
    @(negedge clk);
    rst_n = 1;
    repeat (4) step(1, 1, 0);
    settle();
    chk("R1", "no drive before copy", drv === 1'b0, 64'(drv), 64'(0));
  endtask

  task automatic full_line(int seed);
    repeat (2) step(1, 1, seed);
    step(0, 1, seed);
    step(0, 1, seed + 1);
    step(0, 1, seed + 2);
    settle();
    chk("R4", "held after refill", held === mk(seed), held[63:0], mk(seed)[63:0]);
    repeat (2) step(0, 0, seed + 2);
    settle();
    chk("R5", "convert phase", conv === 1'b1, 64'(conv), 64'(1));
    repeat (2) step(1, 0, seed + 2);
    settle();
    chk("R6", "latch phase", lat === 1'b1, 64'(lat), 64'(1));
    repeat (2) step(1, 1, seed + 3);
    settle();
    chk("R7", "drive phase", drv === 1'b1, 64'(drv), 64'(1));
  endtask

  initial begin
    do_reset();
    full_line(1);
    full_line(2);
    // R9: out-of-order level from drive
    step(1, 0, 9);
    step(1, 1, 9);
    step(1, 1, 9);
    settle();
    chk("R9", "err after bad step", err === 1'b1, 64'(err), 64'(1));
    chk("R9", "no drive after error", drv === 1'b0, 64'(drv), 64'(0));
    // R10: recovery with legal sequence, flag stays
    full_line(5);
    chk("R10", "held after recovery", held === mk(5), held[63:0], mk(5)[63:0]);
    chk("R10", "err still set", err === 1'b1, 64'(err), 64'(1));
    do_reset();
    // skip conversion: copied then both high
    step(0, 1, 11);
    step(1, 1, 12);
    step(1, 1, 12);
    settle();
    chk("R9", "err from copied", err === 1'b1, 64'(err), 64'(1));
    chk("R3", "copy kept", held === mk(11), held[63:0], mk(11)[63:0]);
    do_reset();
    // wrong step out of convert
    step(0, 1, 13);
    step(0, 0, 13);
    step(0, 1, 14);
    step(1, 1, 14);
    settle();
    chk("R9", "err from convert", err === 1'b1, 64'(err), 64'(1));
    chk("R3", "no recopy from convert", held === mk(13), held[63:0], mk(13)[63:0]);
    do_reset();
    full_line(20);
    repeat (3) step(1, 1, 21);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule